// File: doc/BRIEF.md
# Pulse-Height Acquisition Sequencer

This block runs event capture for a pulse-height analyzer. A comparator outside the block goes high while the shaped detector pulse is above a noise threshold. The block synchronizes that signal and counts every rising edge of it in a saturating counter. Counting goes on in every state. The first edge seen while idle starts an acquisition. The block then waits a programmable settle time, gives an external converter a one-cycle start pulse, and waits for its done signal. It captures the 10-bit sample and presents it with a one-cycle valid strobe. Last, it drives a reset pulse of programmable width to the external peak-hold stage.

The acquisition flag stays set from the accepting edge until the peak-hold reset phase ends, so capture is non-paralyzable. Edges that arrive during an acquisition are counted but never start a second one. If the converter fails to answer within a programmable number of cycles, the sequence drops into the reset phase without a result and raises a timeout flag. The flag stays up until the next event is accepted. The settle, reset-width and timeout counts are read from input ports. They should be chosen so that a full sequence fits in about 8 microseconds at the system clock.

Top module: `pha_sequencer`

## Requirements
- R1: `pulse_count` rises by exactly one for each rising edge of `cmp_in`, in every acquisition state. The new value shows after the second clock edge that follows the edge first sampling `cmp_in` high.
- R2: While `busy` is high, further rising edges of `cmp_in` start no acquisition: exactly one `adc_start` pulse is produced per accepted event.
- R3: When idle, a rising edge of `cmp_in` is accepted and `busy` goes high. `adc_start` first goes high on the (S+3)-th clock edge after the edge that first samples `cmp_in` high, where S is `settle_cycles`.
- R4: `adc_start` is high for exactly one clock cycle per acquisition.
- R5: When `adc_done` is sampled high while waiting, `result_valid` is high for exactly the next cycle, and `result_data` equals the `adc_data` sampled with `adc_done`.
- R6: If `adc_done` stays low for T+1 waiting cycles, where T is `timeout_cycles`, the sequence goes to the peak-hold reset phase with no `result_valid`, and `timeout_err` goes high. A done in the last of those cycles is still accepted.
- R7: `hold_reset` starts on the cycle right after `result_valid`, or right after the timeout. It stays high for max(H,1) cycles, where H is `hold_cycles`. `busy` falls together with `hold_reset`.
- R8: `timeout_err` stays high until the next event is accepted, and is low from then on.
- R9: `pulse_count` saturates at all ones. `cnt_clear` zeroes it on the next clock edge and takes priority over an increment.
- R10: While `rst_n` is low, `adc_start`, `hold_reset`, `busy`, `result_valid`, `timeout_err` and `pulse_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_in | input | 1 | Threshold comparator output, asynchronous |
| cnt_clear | input | 1 | Synchronous clear of the pulse counter |
| settle_cycles | input | DLY_W | Settle delay before the converter start |
| hold_cycles | input | DLY_W | Peak-hold reset pulse width (0 acts as 1) |
| timeout_cycles | input | TO_W | Converter done timeout |
| adc_done | input | 1 | Converter conversion-complete |
| adc_data | input | ADC_W | Converter result |
| adc_start | output | 1 | One-cycle converter start |
| hold_reset | output | 1 | Reset to the external peak-hold stage |
| busy | output | 1 | Event latch: acquisition in progress |
| result_valid | output | 1 | One-cycle sample strobe |
| result_data | output | ADC_W | Captured sample |
| timeout_err | output | 1 | Converter timeout flag |
| pulse_count | output | CNT_W | Saturating comparator edge count |

## Verification
The comparator edge takes two synchronizer flops and one edge-detect compare. `busy` and the updated count therefore appear on the third falling-edge sample after `cmp_in` is driven, and `adc_start` appears S+1 samples after that. A `result_valid` is due one sample after `adc_done` is driven. On a timeout, `hold_reset` shows T+1 samples into the wait, and the reset pulse is then counted sample by sample. The bench drives all inputs on falling edges and counts falling edges from each stimulus. Every output is compared at exactly the sample where these latencies place it, across sweeps of settle, reset-width, done-delay and timeout values.

// File: rtl/pha_pkg.sv
package pha_pkg;

  typedef enum logic [2:0] {
    ACQ_IDLE    = 3'd0,
    ACQ_SETTLE  = 3'd1,
    ACQ_START   = 3'd2,
    ACQ_WAIT    = 3'd3,
    ACQ_VALID   = 3'd4,
    ACQ_HOLDRST = 3'd5
  } acq_state_t;

endpackage

// File: rtl/pha_rst_sync.sv
module pha_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pha_cmp_sync.sv
module pha_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  output logic cmp_rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = cmp_async;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], cmp_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign cmp_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pha_event_counter.sv
module pha_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | (inc & (count_q != CNT_MAX));
    count_d  = clr ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/pha_acq_ctrl.sv
module pha_acq_ctrl
  import pha_pkg::*;
#(
  parameter int ADC_W = 10,
  parameter int DLY_W = 8,
  parameter int TO_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_rise,
  input  logic [DLY_W-1:0] settle_cycles,
  input  logic [DLY_W-1:0] hold_cycles,
  input  logic [TO_W-1:0]  timeout_cycles,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic             adc_start,
  output logic             hold_reset,
  output logic             busy,
  output logic             result_valid,
  output logic [ADC_W-1:0] result_data,
  output logic             timeout_err
);

  localparam int CW = (DLY_W > TO_W) ? DLY_W : TO_W;

  acq_state_t       state_q, state_d;
  logic [CW-1:0]    tick_q, tick_d;
  logic             err_q, err_d;
  logic [ADC_W-1:0] sample_q;
  logic             sample_en;
  logic [CW-1:0]    hold_len;
  logic [CW-1:0]    settle_len;
  logic [CW-1:0]    wait_len;

  always_comb begin
    settle_len = CW'(settle_cycles);
    wait_len   = CW'(timeout_cycles);
    hold_len   = (hold_cycles == '0) ? CW'(1) : CW'(hold_cycles);
  end

  always_comb begin
    state_d   = state_q;
    tick_d    = tick_q;
    err_d     = err_q;
    sample_en = 1'b0;
    case (state_q)
      ACQ_IDLE: begin
        if (evt_rise) begin
          state_d = ACQ_SETTLE;
          tick_d  = settle_len;
          err_d   = 1'b0;
        end
      end
      ACQ_SETTLE: begin
        if (tick_q == '0) begin
          state_d = ACQ_START;
        end else begin
          tick_d = tick_q - 1'b1;
        end
      end
      ACQ_START: begin
        state_d = ACQ_WAIT;
        tick_d  = wait_len;
      end
      ACQ_WAIT: begin
        if (adc_done) begin
          state_d   = ACQ_VALID;
          sample_en = 1'b1;
        end else if (tick_q == '0) begin
          state_d = ACQ_HOLDRST;
          tick_d  = hold_len;
          err_d   = 1'b1;
        end else begin
          tick_d = tick_q - 1'b1;
        end
      end
      ACQ_VALID: begin
        state_d = ACQ_HOLDRST;
        tick_d  = hold_len;
      end
      ACQ_HOLDRST: begin
        if (tick_q <= CW'(1)) begin
          state_d = ACQ_IDLE;
        end else begin
          tick_d = tick_q - 1'b1;
        end
      end
      default: begin
        state_d = ACQ_IDLE;
        tick_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACQ_IDLE;
      tick_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else if (sample_en) begin
      sample_q <= adc_data;
    end
  end

  assign adc_start    = (state_q == ACQ_START);
  assign hold_reset   = (state_q == ACQ_HOLDRST);
  assign busy         = (state_q != ACQ_IDLE);
  assign result_valid = (state_q == ACQ_VALID);
  assign result_data  = sample_q;
  assign timeout_err  = err_q;

endmodule

// File: rtl/pha_sequencer.sv
module pha_sequencer #(
  parameter int CNT_W = 32,
  parameter int ADC_W = 10,
  parameter int DLY_W = 8,
  parameter int TO_W  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  input  logic             cnt_clear,
  input  logic [DLY_W-1:0] settle_cycles,
  input  logic [DLY_W-1:0] hold_cycles,
  input  logic [TO_W-1:0]  timeout_cycles,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic             adc_start,
  output logic             hold_reset,
  output logic             busy,
  output logic             result_valid,
  output logic [ADC_W-1:0] result_data,
  output logic             timeout_err,
  output logic [CNT_W-1:0] pulse_count
);

  logic rst_n_int;
  logic cmp_rise;

  pha_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pha_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmp_async (cmp_in),
    .cmp_rise  (cmp_rise)
  );

  pha_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .inc   (cmp_rise),
    .clr   (cnt_clear),
    .count (pulse_count)
  );

  pha_acq_ctrl #(
    .ADC_W (ADC_W),
    .DLY_W (DLY_W),
    .TO_W  (TO_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .evt_rise       (cmp_rise),
    .settle_cycles  (settle_cycles),
    .hold_cycles    (hold_cycles),
    .timeout_cycles (timeout_cycles),
    .adc_done       (adc_done),
    .adc_data       (adc_data),
    .adc_start      (adc_start),
    .hold_reset     (hold_reset),
    .busy           (busy),
    .result_valid   (result_valid),
    .result_data    (result_data),
    .timeout_err    (timeout_err)
  );

endmodule

// File: rtl/pha_sequencer_chk.sv
module pha_sequencer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clear,
  input logic             adc_start,
  input logic             hold_reset,
  input logic             busy,
  input logic             result_valid,
  input logic [CNT_W-1:0] pulse_count
);

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  valid_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> hold_reset);

  // R7
  hold_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_reset |-> busy);

  // R2
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adc_start, result_valid, hold_reset}));

  // R1
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (pulse_count >= $past(pulse_count)));

  // R9
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && (pulse_count == {CNT_W{1'b1}})) |=> (pulse_count == {CNT_W{1'b1}}));

  // R9
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (pulse_count == '0));

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!adc_start && !hold_reset && !busy && !result_valid);
    end
  end

endmodule

bind pha_sequencer pha_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_clear    (cnt_clear),
  .adc_start    (adc_start),
  .hold_reset   (hold_reset),
  .busy         (busy),
  .result_valid (result_valid),
  .pulse_count  (pulse_count)
);

// File: tb/pha_sequencer_test.sv
`timescale 1ns/1ps
module pha_sequencer_test;

  localparam int CNT_W = 4;
  localparam int ADC_W = 10;
  localparam int DLY_W = 8;
  localparam int TO_W  = 8;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmp_in;
  logic             cnt_clear;
  logic [DLY_W-1:0] settle_cycles;
  logic [DLY_W-1:0] hold_cycles;
  logic [TO_W-1:0]  timeout_cycles;
  logic             adc_done;
  logic [ADC_W-1:0] adc_data;
  logic             adc_start;
  logic             hold_reset;
  logic             busy;
  logic             result_valid;
  logic [ADC_W-1:0] result_data;
  logic             timeout_err;
  logic [CNT_W-1:0] pulse_count;

  int total = 0;
  int bad   = 0;
  int starts = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [CNT_W-1:0] exp_cnt;

  always #2.5 clk = ~clk;

  pha_sequencer #(
    .CNT_W (CNT_W),
    .ADC_W (ADC_W),
    .DLY_W (DLY_W),
    .TO_W  (TO_W)
  ) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_in         (cmp_in),
    .cnt_clear      (cnt_clear),
    .settle_cycles  (settle_cycles),
    .hold_cycles    (hold_cycles),
    .timeout_cycles (timeout_cycles),
    .adc_done       (adc_done),
    .adc_data       (adc_data),
    .adc_start      (adc_start),
    .hold_reset     (hold_reset),
    .busy           (busy),
    .result_valid   (result_valid),
    .result_data    (result_data),
    .timeout_err    (timeout_err),
    .pulse_count    (pulse_count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (adc_start) starts <= starts + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  task automatic run_acq(input int s, input int h, input int t, input int d,
                         input bit to, input logic [ADC_W-1:0] dat);
    int n;
    int m;
    int hc;
    bit seen;
    bit rv;
    int hexp;
    @(negedge clk);
    settle_cycles  = DLY_W'(s);
    hold_cycles    = DLY_W'(h);
    timeout_cycles = TO_W'(t);
    cmp_in = 1'b1;
    exp_cnt = bump(exp_cnt);
    n = 0;
    seen = 1'b0;
    while (!seen && n < 600) begin
      @(negedge clk);
      n++;
      if (n == 3) begin
        check(busy == 1'b1, "R3 busy after accept", busy, 1);
        check(pulse_count == exp_cnt, "R1 count", pulse_count, exp_cnt);
        check(timeout_err == 1'b0, "R8 err cleared", timeout_err, 0);
      end
      if (adc_start) seen = 1'b1;
    end
    check(n == s + 4, "R3 settle latency", n, s + 4);
    cmp_in = 1'b0;
    @(negedge clk);
    check(adc_start == 1'b0, "R4 start width", adc_start, 0);
    hexp = (h == 0) ? 1 : h;
    if (!to) begin
      repeat (d) @(negedge clk);
      adc_done = 1'b1;
      adc_data = dat;
      @(negedge clk);
      adc_done = 1'b0;
      check(result_valid == 1'b1, "R5 valid", result_valid, 1);
      check(result_data == dat, "R5 data", result_data, dat);
      @(negedge clk);
      check(result_valid == 1'b0, "R5 valid one cycle", result_valid, 0);
    end else begin
      m = 0;
      rv = 1'b0;
      while (!hold_reset && m < 600) begin
        @(negedge clk);
        m++;
        if (result_valid) rv = 1'b1;
      end
      check(m == t + 1, "R6 timeout latency", m, t + 1);
      check(timeout_err == 1'b1, "R6 timeout flag", timeout_err, 1);
      check(rv == 1'b0, "R6 no result", rv, 0);
    end
    hc = 0;
    while (hold_reset && hc < 600) begin
      hc++;
      @(negedge clk);
    end
    check(hc == hexp, "R7 hold width", hc, hexp);
    check(busy == 1'b0, "R7 busy release", busy, 0);
    if (to) check(timeout_err == 1'b1, "R8 err held", timeout_err, 1);
  endtask

  initial begin
    int s0;
    rst_n = 1'b0;
    cmp_in = 1'b0;
    cnt_clear = 1'b0;
    settle_cycles = '0;
    hold_cycles = '0;
    timeout_cycles = 8'd4;
    adc_done = 1'b0;
    adc_data = '0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    check({adc_start, hold_reset, busy, result_valid, timeout_err} == 5'b0,
          "R10 reset outputs", {adc_start, hold_reset, busy, result_valid, timeout_err}, 0);
    check(pulse_count == '0, "R10 reset count", pulse_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R7 sweep over settle, reset width and done delay
    foreach (exp_cnt[i]) begin end
    for (int si = 0; si < 4; si++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int di = 0; di < 2; di++) begin
          run_acq((si == 3) ? 5 : si, (hi == 2) ? 3 : hi, 4, di * 2, 1'b0,
                  ADC_W'(si * 97 + hi * 31 + di * 500 + 1));
        end
      end
    end
    // R6 done on the last allowed wait cycle is accepted
    run_acq(1, 1, 3, 3, 1'b0, 10'h3FF);
    // R6 timeout, R8 flag persists then clears on next event
    run_acq(2, 2, 0, 0, 1'b1, '0);
    run_acq(0, 0, 3, 0, 1'b1, '0);
    run_acq(1, 1, 2, 0, 1'b0, 10'h155);

    // R9 clear
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    exp_cnt = '0;
    check(pulse_count == '0, "R9 clear", pulse_count, 0);

    // R2 R9 many edges during one long acquisition
    settle_cycles = 8'd200;
    hold_cycles = 8'd1;
    timeout_cycles = 8'd0;
    s0 = starts;
    for (int k = 0; k < 20; k++) begin
      cmp_in = 1'b1;
      @(negedge clk);
      cmp_in = 1'b0;
      @(negedge clk);
      exp_cnt = bump(exp_cnt);
    end
    repeat (3) @(negedge clk);
    check(pulse_count == CMAX, "R9 saturate", pulse_count, CMAX);
    check(exp_cnt == CMAX, "R9 model saturate", exp_cnt, CMAX);
    check(busy == 1'b1, "R2 still busy", busy, 1);
    cnt_clear = 1'b1;
    cmp_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cnt_clear = 1'b0;
    @(negedge clk);
    check(pulse_count == 4'd1, "R9 clear then count", pulse_count, 1);
    cmp_in = 1'b0;
    while (busy && cycles < 5000) @(negedge clk);
    repeat (3) @(negedge clk);
    check(starts - s0 == 1, "R2 single start", starts - s0, 1);
    check(timeout_err == 1'b1, "R6 flag after abort", timeout_err, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule